// File: doc/BRIEF.md
# PTP Time-of-Day Counter with Fractional Nanoseconds

This block keeps precision time as a seconds count and a nanoseconds count. Every clock cycle it adds a programmable increment, a fixed-point nanosecond value with 32 integer and 32 fraction bits, to an internal nanosecond accumulator. The fraction stays hidden and only the integer nanoseconds are readable. Software sets the nominal increment from the clock frequency, which is (10^9 << 32) / f_clk. It trims the frequency at runtime by rewriting the increment while the counter runs.

When the integer nanoseconds reach one billion, the block subtracts exactly 10^9 and advances the seconds count in the same cycle. The overshoot and the fraction are kept, so no error builds up from one second to the next. A pulse-per-second output rises at every second boundary and is shaped by programmable high and low durations. A rising edge on an external event pin, taken through a synchroniser, latches a timestamp that software reads back later.

All access goes through a 64-bit register port. Writes take effect at the clock edge. Read data is registered and is valid on the cycle after the read strobe.

Top module: `tod_counter`

## Requirements
- R1: After reset, nanoseconds, fraction and seconds are zero, `pps_out` is low, the capture flag is clear and the increment register (address 0x0) reads the parameter `RESET_INC`.
- R2: Each clock cycle the 32.32 increment is added to the {nanoseconds, fraction} accumulator. Reading address 0x3 returns the integer nanoseconds in bits [31:0] and takes a snapshot of the seconds value from the same cycle. Address 0x4 then returns that snapshot in bits [47:0].
- R3: A rollover happens when the integer nanoseconds after the add are 1,000,000,000 or more. A value of 999,999,999 does not roll over.
- R4: On rollover the new accumulator value is the sum minus 10^9 × 2^32, so the overshoot and the fraction are kept, and seconds increase by exactly one on that same edge.
- R5: A write to address 0x1 stages nanoseconds (bits [31:0]). A write to address 0x2 loads seconds (bits [47:0]) together with the staged nanoseconds and clears the fraction. This load replaces the add on that edge.
- R6: Address 0x0 holds the increment and can be read back. A value written there is first added on the edge after the write edge, and the add on the write edge itself uses the old value in full.
- R7: `pps_out` goes high on every rollover edge. A phase accumulator, restarted from the new time at each rollover, advances by the increment. The output drops when the phase reaches the high duration (address 0x5) and rises when it reaches the low duration (address 0x6), each duration in 32.32 ns. A rollover takes priority over both. A load clears `pps_out` and the phase.
- R8: The first clock edge on which a rising edge of `ext_evt` appears after two synchroniser flops latches the current seconds and nanoseconds. The capture is readable at 0x8 and 0x7, and it sets a valid flag readable at 0x9 bit 0.
- R9: Reading address 0x7 or 0x8 clears the valid flag, and a new capture in the same cycle wins.
- R10: `rdata` is registered and valid one cycle after `rd_en`. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that drives the time counter |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data |
| ext_evt | input | 1 | Asynchronous timestamp event input |
| pps_out | output | 1 | Pulse-per-second output |

## Verification
The hardest situation to reach from the ports is a second boundary, and within it the exact threshold and a fraction carried across the wrap. At a realistic increment a boundary is more than 10^8 cycles away. The stimulus therefore loads a time a few nanoseconds below 10^9 and steps it with small integer and half-nanosecond increments, so that it lands just under, exactly on, or just past the threshold. A very large increment of 2^28 ns then produces several rollovers and a full pulse-per-second high/low cycle within a few dozen clocks.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 4;
  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;

  localparam logic [ADDR_W-1:0] RA_INC      = 4'h0;
  localparam logic [ADDR_W-1:0] RA_LDNS     = 4'h1;
  localparam logic [ADDR_W-1:0] RA_LDSEC    = 4'h2;
  localparam logic [ADDR_W-1:0] RA_NOW_NS   = 4'h3;
  localparam logic [ADDR_W-1:0] RA_NOW_SEC  = 4'h4;
  localparam logic [ADDR_W-1:0] RA_PPS_HI   = 4'h5;
  localparam logic [ADDR_W-1:0] RA_PPS_LO   = 4'h6;
  localparam logic [ADDR_W-1:0] RA_CAP_NS   = 4'h7;
  localparam logic [ADDR_W-1:0] RA_CAP_SEC  = 4'h8;
  localparam logic [ADDR_W-1:0] RA_CAP_STAT = 4'h9;
endpackage

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int NS_W   = 32,
  parameter int FRAC_W = 32,
  parameter int SEC_W  = 48,
  parameter logic [NS_W-1:0] ROLL_NS = NS_W'(1_000_000_000)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NS_W+FRAC_W-1:0] inc,
  input  logic                   load,
  input  logic [SEC_W-1:0]       load_sec,
  input  logic [NS_W-1:0]        load_ns,
  output logic [NS_W-1:0]        ns,
  output logic [FRAC_W-1:0]      frac,
  output logic [SEC_W-1:0]       sec,
  output logic                   roll,
  output logic [NS_W+FRAC_W-1:0] t_next
);
  localparam int T_W = NS_W + FRAC_W;
  localparam logic [T_W-1:0] ROLL_FIX = {ROLL_NS, {FRAC_W{1'b0}}};

  logic [T_W:0] sum;
  logic         roll_raw;

  always_comb begin
    sum      = {1'b0, ns, frac} + {1'b0, inc};
    roll_raw = (sum >= {1'b0, ROLL_FIX});
    t_next   = roll_raw ? (sum[T_W-1:0] - ROLL_FIX) : sum[T_W-1:0];
    roll     = roll_raw & ~load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns   <= '0;
      frac <= '0;
      sec  <= '0;
    end else if (load) begin
      ns   <= load_ns;
      frac <= '0;
      sec  <= load_sec;
    end else begin
      ns   <= t_next[T_W-1:FRAC_W];
      frac <= t_next[FRAC_W-1:0];
      if (roll_raw) sec <= sec + SEC_W'(1);
    end
  end
endmodule

// File: rtl/tod_pps.sv
module tod_pps #(
  parameter int T_W = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [T_W-1:0] inc,
  input  logic [T_W-1:0] hi_dur,
  input  logic [T_W-1:0] lo_dur,
  input  logic           load,
  input  logic           roll,
  input  logic [T_W-1:0] t_next,
  output logic           pps
);
  logic [T_W-1:0] phase;
  logic [T_W:0]   step;

  always_comb step = {1'b0, phase} + {1'b0, inc};

  always_ff @(posedge clk) begin
    if (rst || load) begin
      pps   <= 1'b0;
      phase <= '0;
    end else if (roll) begin
      pps   <= 1'b1;
      phase <= t_next;
    end else if (pps && step >= {1'b0, hi_dur}) begin
      pps   <= 1'b0;
      phase <= step[T_W-1:0] - hi_dur;
    end else if (!pps && step >= {1'b0, lo_dur}) begin
      pps   <= 1'b1;
      phase <= step[T_W-1:0] - lo_dur;
    end else begin
      phase <= step[T_W-1:0];
    end
  end
endmodule

// File: rtl/tod_evt_cap.sv
module tod_evt_cap #(
  parameter int NS_W   = 32,
  parameter int SEC_W  = 48,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic [NS_W-1:0]  ns,
  input  logic [SEC_W-1:0] sec,
  input  logic             clr,
  output logic [NS_W-1:0]  cap_ns,
  output logic [SEC_W-1:0] cap_sec,
  output logic             valid,
  output logic             rise
);
  logic [SYNC_N:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_N-1:0], evt};
  end

  always_comb rise = sh[SYNC_N-1] & ~sh[SYNC_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_ns  <= '0;
      cap_sec <= '0;
      valid   <= 1'b0;
    end else if (rise) begin
      cap_ns  <= ns;
      cap_sec <= sec;
      valid   <= 1'b1;
    end else if (clr) begin
      valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int NS_W   = 32,
  parameter int FRAC_W = 32,
  parameter int SEC_W  = 48,
  parameter int SYNC_N = 2,
  parameter logic [NS_W+FRAC_W-1:0] RESET_INC = 64'h0000_0008_0000_0000,
  parameter logic [NS_W+FRAC_W-1:0] RESET_DUR = 64'h1DCD_6500_0000_0000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NS_W+FRAC_W-1:0]   wdata,
  output logic [NS_W+FRAC_W-1:0]   rdata,
  input  logic                     ext_evt,
  output logic                     pps_out
);
  localparam int D_W = NS_W + FRAC_W;

  logic [D_W-1:0]    inc_q, hi_q, lo_q;
  logic [NS_W-1:0]   stage_ns;
  logic [SEC_W-1:0]  sec_snap;
  logic              load_fire, cap_clr;
  logic [NS_W-1:0]   cur_ns;
  logic [FRAC_W-1:0] cur_frac;
  logic [SEC_W-1:0]  cur_sec;
  logic              roll_now;
  logic [D_W-1:0]    time_next;
  logic [NS_W-1:0]   cap_ns;
  logic [SEC_W-1:0]  cap_sec;
  logic              cap_valid, evt_rise;

  always_comb begin
    load_fire = wr_en && (addr == RA_LDSEC);
    cap_clr   = rd_en && ((addr == RA_CAP_NS) || (addr == RA_CAP_SEC));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q    <= RESET_INC;
      hi_q     <= RESET_DUR;
      lo_q     <= RESET_DUR;
      stage_ns <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_INC:    inc_q    <= wdata;
        RA_LDNS:   stage_ns <= wdata[NS_W-1:0];
        RA_PPS_HI: hi_q     <= wdata;
        RA_PPS_LO: lo_q     <= wdata;
        default:   ;
      endcase
    end
  end

  tod_accum #(.NS_W(NS_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W),
              .ROLL_NS(NS_PER_SEC[NS_W-1:0])) u_accum (
    .clk(clk), .rst(rst), .inc(inc_q), .load(load_fire),
    .load_sec(wdata[SEC_W-1:0]), .load_ns(stage_ns),
    .ns(cur_ns), .frac(cur_frac), .sec(cur_sec),
    .roll(roll_now), .t_next(time_next));

  tod_pps #(.T_W(D_W)) u_pps (
    .clk(clk), .rst(rst), .inc(inc_q), .hi_dur(hi_q), .lo_dur(lo_q),
    .load(load_fire), .roll(roll_now), .t_next(time_next), .pps(pps_out));

  tod_evt_cap #(.NS_W(NS_W), .SEC_W(SEC_W), .SYNC_N(SYNC_N)) u_cap (
    .clk(clk), .rst(rst), .evt(ext_evt), .ns(cur_ns), .sec(cur_sec),
    .clr(cap_clr), .cap_ns(cap_ns), .cap_sec(cap_sec),
    .valid(cap_valid), .rise(evt_rise));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      sec_snap <= '0;
    end else if (rd_en) begin
      case (addr)
        RA_INC:      rdata <= inc_q;
        RA_LDNS:     rdata <= D_W'(stage_ns);
        RA_NOW_NS: begin
          rdata    <= D_W'(cur_ns);
          sec_snap <= cur_sec;
        end
        RA_NOW_SEC:  rdata <= D_W'(sec_snap);
        RA_PPS_HI:   rdata <= hi_q;
        RA_PPS_LO:   rdata <= lo_q;
        RA_CAP_NS:   rdata <= D_W'(cap_ns);
        RA_CAP_SEC:  rdata <= D_W'(cap_sec);
        RA_CAP_STAT: rdata <= D_W'(cap_valid);
        default:     rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int NS_W   = 32,
  parameter int FRAC_W = 32,
  parameter int SEC_W  = 48
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NS_W-1:0]        ns,
  input logic [FRAC_W-1:0]      frac,
  input logic [SEC_W-1:0]       sec,
  input logic [NS_W+FRAC_W-1:0] inc,
  input logic                   load,
  input logic                   pps,
  input logic                   evt_rise,
  input logic                   cap_valid
);
  localparam logic [NS_W-1:0] LIMIT = NS_W'(1_000_000_000);

  a_r3_ns_below_limit: assert property (@(posedge clk) disable iff (rst)
    ns < LIMIT);

  a_r4_sec_single_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && sec != $past(sec))
      |-> sec == ($past(sec) + SEC_W'(1)));

  a_r4_ns_wraps: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && sec != $past(sec)) |-> ns < $past(ns));

  a_r6_step_uses_prior_inc: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && sec == $past(sec))
      |-> {ns, frac} == ($past({ns, frac}) + $past(inc)));

  a_r5_load_clears_frac: assert property (@(posedge clk) disable iff (rst)
    load |=> frac == '0);

  a_r7_pps_high_on_roll: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && sec != $past(sec)) |-> pps);

  a_r8_rise_sets_valid: assert property (@(posedge clk) disable iff (rst)
    evt_rise |=> cap_valid);
endmodule

bind tod_counter tod_counter_chk #(.NS_W(NS_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst(rst), .ns(cur_ns), .frac(cur_frac), .sec(cur_sec),
  .inc(inc_q), .load(load_fire), .pps(pps_out),
  .evt_rise(evt_rise), .cap_valid(cap_valid));

// File: tb/tb_tod_counter.sv
module tb_tod_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, ext_evt = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        pps_out;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tod_counter dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ext_evt(ext_evt), .pps_out(pps_out));

  localparam logic [3:0] A_INC = 4'h0, A_LDNS = 4'h1, A_LDSEC = 4'h2,
    A_NS = 4'h3, A_SEC = 4'h4, A_HI = 4'h5, A_LO = 4'h6,
    A_CNS = 4'h7, A_CSEC = 4'h8, A_STAT = 4'h9;

  localparam int NV = 8;
  localparam logic [63:0] V_INC [NV] = '{64'h0000_0008_0000_0000, 64'h0000_0008_0000_0000,
    64'h0000_0008_0000_0000, 64'h0000_0008_0000_0000, 64'h0000_0008_8000_0000,
    64'h0000_0008_8000_0000, 64'h1000_0000_0000_0000, 64'h0000_0008_8000_0000};
  localparam logic [31:0] V_NS [NV] = '{32'd100, 32'd999_999_990, 32'd999_999_992,
    32'd999_999_991, 32'd0, 32'd999_999_995, 32'd0, 32'd0};
  localparam logic [47:0] V_SEC [NV] = '{48'd5, 48'd7, 48'd0, 48'd0, 48'd0, 48'd9, 48'd100, 48'd0};
  localparam int V_WAIT [NV] = '{10, 2, 1, 1, 3, 2, 10, 4};
  localparam logic [31:0] E_NS [NV] = '{32'd180, 32'd6, 32'd0, 32'd999_999_999,
    32'd25, 32'd12, 32'd684_354_560, 32'd34};
  localparam logic [47:0] E_SEC [NV] = '{48'd5, 48'd8, 48'd1, 48'd0, 48'd0, 48'd10, 48'd102, 48'd0};
  localparam string V_REQ [NV] = '{"R2", "R4", "R3", "R3", "R2", "R4", "R4", "R2"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    bit exp_pps [9] = '{0, 0, 0, 0, 1, 1, 0, 0, 1};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_NS, d);   chk("R1 ns", d, 64'd0);
    rd(A_SEC, d);  chk("R1 sec", d, 64'd0);
    rd(A_INC, d);  chk("R1 inc", d, 64'h0000_0008_0000_0000);
    rd(A_STAT, d); chk("R1 flag", d, 64'd0);
    chk("R1 pps", {63'd0, pps_out}, 64'd0);
    // R10 unmapped address
    rd(4'hF, d);   chk("R10 unmapped", d, 64'd0);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      wr(A_INC, V_INC[i]);
      wr(A_LDNS, {32'd0, V_NS[i]});
      wr(A_LDSEC, {16'd0, V_SEC[i]});
      repeat (V_WAIT[i]) @(negedge clk);
      rd(A_NS, d);  chk({V_REQ[i], " ns"}, d, {32'd0, E_NS[i]});
      rd(A_SEC, d); chk({V_REQ[i], " sec R5"}, d, {16'd0, E_SEC[i]});
    end

    // R6 increment change mid-run
    wr(A_INC, 64'h0000_0008_0000_0000);
    wr(A_LDNS, 64'd0);
    wr(A_LDSEC, 64'd0);
    wr(A_INC, 64'h0000_0010_0000_0000);
    rd(A_NS, d); chk("R6 old inc on write edge", d, 64'd8);
    rd(A_NS, d); chk("R6 new inc next edge", d, 64'd24);
    rd(A_INC, d); chk("R6 readback", d, 64'h0000_0010_0000_0000);

    // R7 pulse per second
    wr(A_INC, 64'h1000_0000_0000_0000);
    wr(A_HI, 64'h1DCD_6500_0000_0000);
    wr(A_LO, 64'h35A4_E900_0000_0000);
    wr(A_LDNS, 64'd0);
    wr(A_LDSEC, 64'd0);
    chk("R7 pps after load", {63'd0, pps_out}, 64'd0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk($sformatf("R7 pps edge %0d", k), {63'd0, pps_out}, {63'd0, exp_pps[k]});
    end

    // R8 R9 event capture
    wr(A_INC, 64'h0000_0008_0000_0000);
    wr(A_LDNS, 64'd0);
    wr(A_LDSEC, 64'd3);
    ext_evt = 1'b1;
    repeat (6) @(negedge clk);
    rd(A_STAT, d); chk("R8 flag set", d, 64'd1);
    rd(A_CSEC, d); chk("R8 cap sec", d, 64'd3);
    rd(A_STAT, d); chk("R9 flag cleared", d, 64'd0);
    rd(A_CNS, d);  chk("R8 cap ns", d, 64'd16);
    ext_evt = 1'b0;

    finish_run();
  end
endmodule